// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit owns the program counter of a 32-bit core whose instructions sit on word boundaries. For each issued instruction it takes the decoded operation class, a condition selector, the immediates, the index of the first source register and the two source register values, and works out where fetch goes next. Conditional branches compare the two register values with each other; no flags are involved. Branch, immediate-branch and call offsets count in words. Calls also hand back a return address for the register file.

When an instruction must trap, the unit holds the PC at the trapping instruction's own address and moves into a trap state. The trap state shows a cause code until the exception logic outside the unit supplies a handler address on `resume_pc` and pulses `resume`. Register branches through the exception-return or breakpoint-return register raise a one-cycle pulse. The interrupt-enable logic uses that pulse to restore its saved bits.

The control is a two-state machine. **RUN**: instructions are accepted. **TRAP**: instructions are ignored and the cause is held. Transitions: *fault* (RUN to TRAP, when an issued instruction raises any cause), *resume* (TRAP to RUN, loading `resume_pc`) and *stay* (every other cycle keeps the state).

Top module: `nextpc_unit`

## Requirements
- R1: After reset the unit is in RUN with `pc_o` = RESET_PC (default 0x0000_0100), `trap_o` = 0 and `cause_o` = 0.
- R2: `op` = 1 is a conditional branch. `cond` selects the test of ra against rb: 0 equal, 1 not equal, 2 signed greater, 3 signed greater-or-equal, 4 unsigned greater, 5 unsigned greater-or-equal. When the test holds, the next PC is pc + sign-extended({imm16, 2'b00}).
- R3: A conditional branch whose test fails, an `op` = 0 sequential instruction, and a divide (`op` = 7) with a nonzero divisor all advance to pc + 4. A cycle without `issue` in RUN keeps the PC.
- R4: `op` = 2 (immediate branch) and `op` = 4 (immediate call) go to pc + sign-extended({imm26, 2'b00}).
- R5: `op` = 3 (register call) and `op` = 4 assert `link_we_o` with `link_data_o` = pc + 4, intended for return-address register 29. The register call jumps to ra. No other operation asserts `link_we_o`.
- R6: `op` = 5 jumps to ra. `exc_ret_o` pulses when `rsel` = 30 and `brk_ret_o` pulses when `rsel` = 31, in the cycle that the branch is accepted.
- R7: `op` = 6 with `imm5` = 7 raises cause 1 (system call), and with `imm5` = 2 raises cause 2 (breakpoint). The PC stays at the instruction's own address.
- R8: `op` = 7 with `div_zero` high raises cause 3 and keeps `div_commit_o` low. With `div_zero` low, `div_commit_o` is high.
- R9: `op` values 8 to 15, `cond` values 6 and 7 on a conditional branch, and `imm5` values other than 2 or 7 on `op` = 6 raise cause 4 (illegal) and hold the PC.
- R10: An instruction issued while pc[1:0] is nonzero raises cause 5 (misaligned). This cause takes priority over every other outcome.
- R11: In TRAP, issued instructions have no effect: `pc_o` and `cause_o` hold, and `link_we_o`, `div_commit_o` and the return pulses stay low. `resume` loads `resume_pc`, clears the cause and returns to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| op | input | 4 | Operation class |
| cond | input | 3 | Branch condition selector |
| rsel | input | 5 | Index of the first source register |
| imm5 | input | 5 | Trap selector field |
| imm16 | input | 16 | Short word offset |
| imm26 | input | 26 | Long word offset |
| ra_val | input | 32 | First source register value |
| rb_val | input | 32 | Second source register value |
| div_zero | input | 1 | Divisor of a divide is zero |
| resume | input | 1 | Leave TRAP |
| resume_pc | input | 32 | PC loaded on resume |
| pc_o | output | 32 | Current PC |
| next_pc_o | output | 32 | PC after this cycle's edge |
| link_we_o | output | 1 | Write return address |
| link_data_o | output | 32 | Return address value |
| div_commit_o | output | 1 | Divide result may be written |
| exc_ret_o | output | 1 | Exception return accepted |
| brk_ret_o | output | 1 | Breakpoint return accepted |
| trap_o | output | 1 | Unit is in TRAP |
| cause_o | output | 3 | Held exception cause |

## Verification
The bench uses the default parameters: 32-bit words, a 16-bit short offset and a 26-bit long offset. With these values, negative offsets can wrap the PC across zero, and signed and unsigned compares give different answers on operands whose top bits differ. Small random operand values make equal and near-equal compares common. Register jumps to an odd address set up misaligned PCs, so the priority of the misaligned cause is tested.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
    localparam logic [3:0] OP_SEQ   = 4'd0;
    localparam logic [3:0] OP_BCOND = 4'd1;
    localparam logic [3:0] OP_BI    = 4'd2;
    localparam logic [3:0] OP_CALL  = 4'd3;
    localparam logic [3:0] OP_CALLI = 4'd4;
    localparam logic [3:0] OP_BREG  = 4'd5;
    localparam logic [3:0] OP_TRAPI = 4'd6;
    localparam logic [3:0] OP_DIVU  = 4'd7;

    localparam logic [2:0] C_NONE     = 3'd0;
    localparam logic [2:0] C_SYSCALL  = 3'd1;
    localparam logic [2:0] C_BREAK    = 3'd2;
    localparam logic [2:0] C_DIVZERO  = 3'd3;
    localparam logic [2:0] C_ILLEGAL  = 3'd4;
    localparam logic [2:0] C_MISALIGN = 3'd5;

    typedef enum logic {ST_RUN, ST_TRAP} fsm_e;
endpackage

// File: rtl/nextpc_cmp.sv
module nextpc_cmp #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            taken,
    output logic            bad_cond
);
    logic eq, gts, gtu;

    assign eq  = (a == b);
    assign gts = ($signed(a) > $signed(b));
    assign gtu = (a > b);

    always_comb begin
        taken    = 1'b0;
        bad_cond = 1'b0;
        unique case (cond)
            3'd0:    taken = eq;
            3'd1:    taken = !eq;
            3'd2:    taken = gts;
            3'd3:    taken = gts || eq;
            3'd4:    taken = gtu;
            3'd5:    taken = gtu || eq;
            default: bad_cond = 1'b1;
        endcase
    end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target #(
    parameter int XLEN  = 32,
    parameter int IMM_S = 16,
    parameter int IMM_L = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_S-1:0] imm_s,
    input  logic [IMM_L-1:0] imm_l,
    output logic [XLEN-1:0]  seq_tgt,
    output logic [XLEN-1:0]  near_tgt,
    output logic [XLEN-1:0]  far_tgt
);
    localparam int SW = IMM_S + 2;
    localparam int LW = IMM_L + 2;

    logic [XLEN-1:0] off_s, off_l;

    generate
        if (XLEN > LW) begin : g_ext
            assign off_s = {{(XLEN-SW){imm_s[IMM_S-1]}}, imm_s, 2'b00};
            assign off_l = {{(XLEN-LW){imm_l[IMM_L-1]}}, imm_l, 2'b00};
        end else begin : g_trunc
            logic [SW-1:0] ws;
            logic [LW-1:0] wl;
            assign ws    = {imm_s, 2'b00};
            assign wl    = {imm_l, 2'b00};
            assign off_s = ws[XLEN-1:0];
            assign off_l = wl[XLEN-1:0];
        end
    endgenerate

    assign seq_tgt  = pc + XLEN'(4);
    assign near_tgt = pc + off_s;
    assign far_tgt  = pc + off_l;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          REG_W       = 5,
    parameter int          IMM_S       = 16,
    parameter int          IMM_L       = 26,
    parameter int          SEL_W       = 5,
    parameter logic [31:0] RESET_PC    = 32'h0000_0100,
    parameter int          EXC_RET_REG = 30,
    parameter int          BRK_RET_REG = 31,
    parameter int          SCALL_CODE  = 7,
    parameter int          BREAK_CODE  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [3:0]       op,
    input  logic [2:0]       cond,
    input  logic [REG_W-1:0] rsel,
    input  logic [SEL_W-1:0] imm5,
    input  logic [IMM_S-1:0] imm16,
    input  logic [IMM_L-1:0] imm26,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  rb_val,
    input  logic             div_zero,
    input  logic             resume,
    input  logic [XLEN-1:0]  resume_pc,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             link_we_o,
    output logic [XLEN-1:0]  link_data_o,
    output logic             div_commit_o,
    output logic             exc_ret_o,
    output logic             brk_ret_o,
    output logic             trap_o,
    output logic [2:0]       cause_o
);
    fsm_e            state_q, state_d;
    logic [XLEN-1:0] pc_q;
    logic [2:0]      cause_q, cause_d;

    logic            taken, bad_cond;
    logic [XLEN-1:0] seq_tgt, near_tgt, far_tgt;

    logic [XLEN-1:0] dec_tgt;
    logic [2:0]      dec_exc, exc;
    logic            dec_link, dec_div;
    logic            accept;

    nextpc_cmp #(.XLEN(XLEN)) u_cmp (
        .cond(cond), .a(ra_val), .b(rb_val),
        .taken(taken), .bad_cond(bad_cond)
    );

    nextpc_target #(.XLEN(XLEN), .IMM_S(IMM_S), .IMM_L(IMM_L)) u_tgt (
        .pc(pc_q), .imm_s(imm16), .imm_l(imm26),
        .seq_tgt(seq_tgt), .near_tgt(near_tgt), .far_tgt(far_tgt)
    );

    // Decode of the issued operation, independent of the state.
    always_comb begin
        dec_tgt  = seq_tgt;
        dec_exc  = C_NONE;
        dec_link = 1'b0;
        dec_div  = 1'b0;
        unique case (op)
            OP_SEQ:   dec_tgt = seq_tgt;
            OP_BCOND: begin
                if (bad_cond)   dec_exc = C_ILLEGAL;
                else if (taken) dec_tgt = near_tgt;
            end
            OP_BI:    dec_tgt = far_tgt;
            OP_CALL:  begin dec_tgt = ra_val;  dec_link = 1'b1; end
            OP_CALLI: begin dec_tgt = far_tgt; dec_link = 1'b1; end
            OP_BREG:  dec_tgt = ra_val;
            OP_TRAPI: begin
                if (imm5 == SEL_W'(SCALL_CODE))      dec_exc = C_SYSCALL;
                else if (imm5 == SEL_W'(BREAK_CODE)) dec_exc = C_BREAK;
                else                                 dec_exc = C_ILLEGAL;
            end
            OP_DIVU:  begin
                if (div_zero) dec_exc = C_DIVZERO;
                else          dec_div = 1'b1;
            end
            default:  dec_exc = C_ILLEGAL;
        endcase
    end

    assign exc    = (|pc_q[1:0]) ? C_MISALIGN : dec_exc;
    assign accept = (state_q == ST_RUN) && issue && (exc == C_NONE);

    // Next-state and output process.
    always_comb begin
        state_d      = state_q;
        cause_d      = cause_q;
        next_pc_o    = pc_q;
        link_we_o    = 1'b0;
        div_commit_o = 1'b0;
        exc_ret_o    = 1'b0;
        brk_ret_o    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (issue) begin
                    if (exc != C_NONE) begin
                        state_d = ST_TRAP;
                        cause_d = exc;
                    end else begin
                        next_pc_o    = dec_tgt;
                        link_we_o    = dec_link;
                        div_commit_o = dec_div;
                        exc_ret_o    = (op == OP_BREG) && (rsel == REG_W'(EXC_RET_REG));
                        brk_ret_o    = (op == OP_BREG) && (rsel == REG_W'(BRK_RET_REG));
                    end
                end
            end
            ST_TRAP: begin
                if (resume) begin
                    state_d   = ST_RUN;
                    cause_d   = C_NONE;
                    next_pc_o = resume_pc;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= RESET_PC[XLEN-1:0];
            cause_q <= C_NONE;
        end else begin
            state_q <= state_d;
            pc_q    <= next_pc_o;
            cause_q <= cause_d;
        end
    end

    assign link_data_o = seq_tgt;
    assign pc_o        = pc_q;
    assign trap_o      = (state_q == ST_TRAP);
    assign cause_o     = cause_q;

    logic unused_accept;
    assign unused_accept = accept;
endmodule

// File: rtl/nextpc_unit_checker.sv
module nextpc_unit_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue,
    input logic            resume,
    input logic [XLEN-1:0] resume_pc,
    input logic [XLEN-1:0] pc_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_data_o,
    input logic            div_commit_o,
    input logic            exc_ret_o,
    input logic            brk_ret_o,
    input logic            trap_o,
    input logic [2:0]      cause_o
);
    assert_link_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_data_o == pc_o + XLEN'(4)) && !trap_o);

    assert_link_no_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |=> !trap_o);

    assert_ret_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_ret_o && brk_ret_o));

    assert_fault_holds_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_o) |-> $stable(pc_o));

    assert_div_commit_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_commit_o |-> !trap_o && issue);

    assert_cause_matches_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o == (cause_o != 3'd0));

    assert_trap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !resume) |=> trap_o && $stable(pc_o) && $stable(cause_o));

    assert_resume_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && resume) |=> !trap_o && (pc_o == $past(resume_pc)));
endmodule

bind nextpc_unit nextpc_unit_checker #(.XLEN(XLEN)) u_checker (
    .clk(clk), .rst_n(rst_n), .issue(issue), .resume(resume),
    .resume_pc(resume_pc), .pc_o(pc_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .div_commit_o(div_commit_o),
    .exc_ret_o(exc_ret_o), .brk_ret_o(brk_ret_o), .trap_o(trap_o),
    .cause_o(cause_o)
);

// File: tb/nextpc_unit_test.sv
`timescale 1ns/100ps
module nextpc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = '0;
    logic [2:0]  cond = '0;
    logic [4:0]  rsel = '0;
    logic [4:0]  imm5 = '0;
    logic [15:0] imm16 = '0;
    logic [25:0] imm26 = '0;
    logic [31:0] ra_val = '0, rb_val = '0, resume_pc = '0;
    logic        div_zero = 1'b0, resume = 1'b0;
    logic [31:0] pc_o, next_pc_o, link_data_o;
    logic        link_we_o, div_commit_o, exc_ret_o, brk_ret_o, trap_o;
    logic [2:0]  cause_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [31:0] m_pc;
    logic        m_trap;
    logic [2:0]  m_cause;

    always #2.5 clk = ~clk;

    nextpc_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .cond(cond),
        .rsel(rsel), .imm5(imm5), .imm16(imm16), .imm26(imm26),
        .ra_val(ra_val), .rb_val(rb_val), .div_zero(div_zero),
        .resume(resume), .resume_pc(resume_pc), .pc_o(pc_o),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o),
        .link_data_o(link_data_o), .div_commit_o(div_commit_o),
        .exc_ret_o(exc_ret_o), .brk_ret_o(brk_ret_o), .trap_o(trap_o),
        .cause_o(cause_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cmp_ok(logic [2:0] c, logic [31:0] a, logic [31:0] b);
        case (c)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) > $signed(b);
            3'd3: return $signed(a) >= $signed(b);
            3'd4: return a > b;
            default: return a >= b;
        endcase
    endfunction

    function automatic logic [2:0] ref_cause();
        if (m_pc[1:0] != 2'b00) return 3'd5;
        if (op > 4'd7) return 3'd4;
        if (op == 4'd1 && cond > 3'd5) return 3'd4;
        if (op == 4'd6) return (imm5 == 5'd7) ? 3'd1 : (imm5 == 5'd2) ? 3'd2 : 3'd4;
        if (op == 4'd7 && div_zero) return 3'd3;
        return 3'd0;
    endfunction

    function automatic logic [31:0] ref_target();
        logic [31:0] s16, s26;
        s16 = {{14{imm16[15]}}, imm16, 2'b00};
        s26 = {{4{imm26[25]}}, imm26, 2'b00};
        case (op)
            4'd1: return cmp_ok(cond, ra_val, rb_val) ? m_pc + s16 : m_pc + 32'd4;
            4'd2, 4'd4: return m_pc + s26;
            4'd3, 4'd5: return ra_val;
            default: return m_pc + 32'd4;
        endcase
    endfunction

    // Checks the present cycle against the model, then advances the model.
    task automatic check_cycle(string tag);
        logic [2:0]  c;
        logic [31:0] nxt;
        logic        acc;
        check({tag, " R1/R11 pc"}, pc_o, m_pc);
        check({tag, " R9 trap"}, {31'd0, trap_o}, {31'd0, m_trap});
        check({tag, " R9 cause"}, {29'd0, cause_o}, {29'd0, m_cause});
        c   = ref_cause();
        acc = !m_trap && issue && c == 3'd0;
        if (m_trap) nxt = resume ? resume_pc : m_pc;
        else if (!issue || c != 3'd0) nxt = m_pc;
        else nxt = ref_target();
        check({tag, " R2/R3/R4 next_pc"}, next_pc_o, nxt);
        check({tag, " R5 link_we"}, {31'd0, link_we_o}, {31'd0, acc && (op == 4'd3 || op == 4'd4)});
        if (acc && (op == 4'd3 || op == 4'd4))
            check({tag, " R5 link_data"}, link_data_o, m_pc + 32'd4);
        check({tag, " R8 div_commit"}, {31'd0, div_commit_o}, {31'd0, acc && op == 4'd7});
        check({tag, " R6 exc_ret"}, {31'd0, exc_ret_o}, {31'd0, acc && op == 4'd5 && rsel == 5'd30});
        check({tag, " R6 brk_ret"}, {31'd0, brk_ret_o}, {31'd0, acc && op == 4'd5 && rsel == 5'd31});
        if (m_trap) begin
            if (resume) begin m_trap = 1'b0; m_cause = 3'd0; end
        end else if (issue && c != 3'd0) begin
            m_trap = 1'b1; m_cause = c;
        end
        m_pc = nxt;
    endtask

    task automatic drive(logic iss, logic [3:0] o, logic [2:0] cd, logic [4:0] rs,
                         logic [4:0] i5, logic [15:0] i16, logic [25:0] i26,
                         logic [31:0] a, logic [31:0] b, logic dz, logic rsm,
                         logic [31:0] rpc, string tag);
        @(negedge clk);
        issue = iss; op = o; cond = cd; rsel = rs; imm5 = i5; imm16 = i16;
        imm26 = i26; ra_val = a; rb_val = b; div_zero = dz; resume = rsm;
        resume_pc = rpc;
        #1;
        check_cycle(tag);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = 32'h100; m_trap = 1'b0; m_cause = 3'd0;
        #1;
        check("R1 reset pc", pc_o, 32'h100);
        check("R1 reset trap", {31'd0, trap_o}, 32'd0);
        check("R1 reset cause", {29'd0, cause_o}, 32'd0);

        // directed corner cases
        drive(1, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 seq");
        drive(1, 4'd1, 3'd2, 0, 0, 16'hFFFF, 0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R2 signed gt false");
        drive(1, 4'd1, 3'd4, 0, 0, 16'hFFFE, 0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R2 unsigned gt taken back");
        drive(1, 4'd1, 3'd5, 0, 0, 16'h0003, 0, 32'd7, 32'd7, 0, 0, 0, "R2 geu equal");
        drive(1, 4'd4, 0, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 0, 0, 0, "R4 R5 calli back");
        drive(1, 4'd2, 0, 0, 0, 0, 26'h000_0010, 0, 0, 0, 0, 0, "R4 bi fwd");
        drive(1, 4'd3, 0, 5'd3, 0, 0, 0, 32'h0000_2000, 0, 0, 0, 0, "R5 call");
        drive(1, 4'd5, 0, 5'd30, 0, 0, 0, 32'h0000_3000, 0, 0, 0, 0, "R6 eret");
        drive(1, 4'd5, 0, 5'd31, 0, 0, 0, 32'h0000_3100, 0, 0, 0, 0, "R6 bret");
        drive(1, 4'd6, 0, 0, 5'd7, 0, 0, 0, 0, 0, 0, 0, "R7 scall");
        drive(1, 4'd3, 0, 0, 0, 0, 0, 32'h5000, 0, 0, 0, 0, "R11 ignored in trap");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4000, "R11 resume");
        drive(1, 4'd6, 0, 0, 5'd2, 0, 0, 0, 0, 0, 0, 0, "R7 break");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4100, "R11 resume");
        drive(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 divzero");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4200, "R11 resume");
        drive(1, 4'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 div ok");
        drive(1, 4'd1, 3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 bad cond");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4300, "R11 resume");
        drive(1, 4'd6, 0, 0, 5'd5, 0, 0, 0, 0, 0, 0, 0, "R9 bad imm5");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4400, "R11 resume");
        drive(1, 4'd12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 bad op");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4500, "R11 resume");
        drive(1, 4'd5, 0, 5'd4, 0, 0, 0, 32'h0000_6002, 0, 0, 0, 0, "R10 jump odd");
        drive(1, 4'd6, 0, 0, 5'd7, 0, 0, 0, 0, 0, 0, 0, "R10 misalign priority");
        drive(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h4600, "R11 resume");
        drive(0, 4'd3, 0, 0, 0, 0, 0, 32'h7000, 0, 0, 0, 0, "R3 idle holds");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  o;
            logic [31:0] a, b;
            int          pick;
            pick = $urandom_range(0, 99);
            if (pick < 10)      o = 4'd0;
            else if (pick < 45) o = 4'd1;
            else if (pick < 52) o = 4'd2;
            else if (pick < 58) o = 4'd3;
            else if (pick < 64) o = 4'd4;
            else if (pick < 74) o = 4'd5;
            else if (pick < 80) o = 4'd6;
            else if (pick < 94) o = 4'd7;
            else                o = 4'($urandom_range(8, 15));
            if ($urandom_range(0, 1) == 0) begin
                a = 32'($urandom_range(0, 3)) - 32'd1;
                b = 32'($urandom_range(0, 3)) - 32'd1;
            end else begin
                a = $urandom; b = $urandom;
            end
            if ((o == 4'd3 || o == 4'd5) && $urandom_range(0, 15) != 0) a[1:0] = 2'b00;
            drive($urandom_range(0, 7) != 0, o, 3'($urandom_range(0, 6)),
                  5'($urandom_range(28, 31)),
                  ($urandom_range(0, 5) == 0) ? 5'($urandom) : (($urandom_range(0, 1) != 0) ? 5'd7 : 5'd2),
                  16'($urandom), 26'($urandom), a, b,
                  $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                  {$urandom_range(0, 32'h3FFF_FFFF), 2'b00}, "random");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule